// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator with All-Zero Check

This block sits at the front of a Reed-Solomon decoder for 31-symbol codewords over GF(32). A shift stage ahead of it delivers one 5-bit received symbol per clock. The same stream also feeds a codeword buffer elsewhere. A start pulse comes with the first symbol. From then on the block folds each symbol into four running syndromes, using Horner's rule for the evaluation points alpha^1 to alpha^4.

One cycle after the 31st symbol has been absorbed, the block tests all four syndromes. If every syndrome is zero, it raises a no-error flag and the decode ends there. Otherwise it raises a syndrome-ready flag, which tells the error-locator solver that the four syndrome buses hold valid values. Both the flags and the syndromes hold their values until the next start pulse.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While reset is held and after it is released, both flags are low and all four syndrome buses read zero until the first start pulse.
- R2: On the clock edge where start is high, every syndrome register is loaded with that cycle's symbol, and any earlier value is discarded.
- R3: Each final syndrome j (1 to 4) equals the sum over i of r_i·alpha^(j·(30−i)), where r_0 is the symbol that arrived with start and r_30 is the 31st symbol. Arithmetic is in GF(32) built on x^5+x^2+1, alpha is 5'b00010, and a bus bit n is the coefficient of x^n.
- R4: Neither flag rises before the edge that follows the edge that took in the 31st symbol. At that edge exactly one flag goes high.
- R5: When all four syndromes are zero at evaluation, the no-error flag goes high and the ready flag stays low.
- R6: When any syndrome is nonzero at evaluation, the ready flag goes high and the no-error flag stays low.
- R7: After evaluation, the flags and syndromes stay unchanged, whatever the symbol input does, until the next start pulse. That start pulse clears both flags.
- R8: A start pulse in the middle of a codeword restarts accumulation from that symbol. The flags then follow the 31 symbols counted from the new start.
- R9: The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | High for one cycle alongside the first symbol |
| sym_i | input | 5 | Received symbol, highest-order first |
| syn1_o | output | 5 | Syndrome at alpha^1 |
| syn2_o | output | 5 | Syndrome at alpha^2 |
| syn3_o | output | 5 | Syndrome at alpha^3 |
| syn4_o | output | 5 | Syndrome at alpha^4 |
| no_err_o | output | 1 | All syndromes were zero: the codeword is clean |
| syn_ready_o | output | 1 | Syndromes are valid and nonzero: start the locator solver |

## Verification
The assertions assume that symbols after a start arrive on consecutive cycles with no gaps, and that start is a single-cycle pulse. The block has no valid qualifier, so a gap would be absorbed as a symbol. The stimulus therefore drives each codeword as an unbroken run of 31 cycles. It pulses start only at the beginning of a word, or on purpose in the middle of one to exercise a restart. Clean codewords are built in the bench by multiplying random messages by the generator with roots alpha^1 to alpha^4. Single-error and fully random words cover the ready path.

// File: rtl/rs_syn_pkg.sv
// Package for the syndrome calculator.
// Holds the field parameters, the symbol type and the GF(32) helper functions.
// Assumes a polynomial basis where bit n is the coefficient of x^n.
package rs_syn_pkg;
    parameter int SYM_W = 5;
    parameter int N_SYM = 31;
    parameter int N_SYN = 4;
    // Low part of the primitive polynomial x^5 + x^2 + 1.
    parameter logic [SYM_W-1:0] PRIM_LOW = 5'b00101;

    typedef logic [SYM_W-1:0] sym_t;

    // Multiply by alpha once: shift left, then reduce if the top bit falls out.
    function automatic sym_t gf_xtime(input sym_t x);
        sym_t r;
        r = {x[SYM_W-2:0], 1'b0};
        if (x[SYM_W-1]) r = r ^ PRIM_LOW;
        return r;
    endfunction

    // Multiply by alpha^j. When j is constant this reduces to a fixed XOR network.
    function automatic sym_t gf_mul_apow(input sym_t x, input int j);
        sym_t r;
        r = x;
        for (int k = 0; k < j; k++) r = gf_xtime(r);
        return r;
    endfunction
endpackage

// File: rtl/rs_gf_constmul.sv
// Fixed multiplier by alpha^J in GF(32).
// Purely combinational. J must be a small non-negative constant.
module rs_gf_constmul
    import rs_syn_pkg::*;
#(
    parameter int J = 1
) (
    input  sym_t a_i,
    output sym_t p_o
);
    // Unrolled multiply-by-alpha chain, which folds into XOR gates.
    always_comb p_o = gf_mul_apow(a_i, J);
endmodule

// File: rtl/rs_syn_cell.sv
// One syndrome accumulator, evaluated at alpha^J.
// Start loads the incoming symbol. While enabled, each cycle computes s*alpha^J + symbol.
// Assumes start and enable are never both needed in the same cycle; start wins.
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter int J = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic acc_en_i,
    input  sym_t sym_i,
    output sym_t syn_o
);
    sym_t scaled;

    rs_gf_constmul #(.J(J)) u_mul (
        .a_i (syn_o),
        .p_o (scaled)
    );

    // Horner step, with a fresh load on start.
    always_ff @(posedge clk) begin
        if (!rst_n)        syn_o <= '0;
        else if (start_i)  syn_o <= sym_i;
        else if (acc_en_i) syn_o <= scaled ^ sym_i;
    end

    // A start edge leaves exactly the symbol that came with it.
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (syn_o == $past(sym_i)));
endmodule

// File: rtl/rs_syn_ctrl.sv
// Sequencer for the syndrome calculator.
// Counts symbols from start and enables accumulation for the remaining N_SYM-1 symbols.
// One cycle later it evaluates the all-zero input and raises exactly one flag.
// Assumes the symbols arrive back to back after start.
module rs_syn_ctrl
    import rs_syn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic all_zero_i,
    output logic acc_en_o,
    output logic no_err_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(N_SYM + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SYM);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Accumulate until the count reaches the last symbol.
    always_comb acc_en_o = busy && (cnt != LAST);

    // Symbol counter, run state and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            no_err_o <= 1'b0;
            ready_o  <= 1'b0;
        end else if (start_i) begin
            busy     <= 1'b1;
            cnt      <= CNT_W'(1);
            no_err_o <= 1'b0;
            ready_o  <= 1'b0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy     <= 1'b0;
                no_err_o <= all_zero_i;
                ready_o  <= !all_zero_i;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(no_err_o && ready_o));
    // A flag can only rise out of a run that has just completed its count.
    assert_flag_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(no_err_o) || $rose(ready_o)) |-> ($past(busy) && !$past(acc_en_o)));
    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!no_err_o && !ready_o));
endmodule

// File: rtl/rs_syndrome_calc.sv
// Top of the syndrome calculator.
// Builds four Horner accumulators at alpha^1..alpha^4 and a sequencer that counts symbols.
// After the last symbol it raises no-error or syndrome-ready, based on an all-zero test.
// Assumes one symbol per cycle from start onwards and start as a one-cycle pulse.
module rs_syndrome_calc
    import rs_syn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] syn1_o,
    output logic [SYM_W-1:0] syn2_o,
    output logic [SYM_W-1:0] syn3_o,
    output logic [SYM_W-1:0] syn4_o,
    output logic             no_err_o,
    output logic             syn_ready_o
);
    sym_t syn [N_SYN];
    logic acc_en;
    logic all_zero;

    // One accumulator per syndrome index, evaluated at alpha^(g+1).
    for (genvar g = 0; g < N_SYN; g++) begin : g_cell
        rs_syn_cell #(.J(g + 1)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start_i),
            .acc_en_i (acc_en),
            .sym_i    (sym_i),
            .syn_o    (syn[g])
        );
    end

    // Zero test across all syndromes.
    always_comb begin
        all_zero = 1'b1;
        for (int k = 0; k < N_SYN; k++)
            if (syn[k] != '0) all_zero = 1'b0;
    end

    rs_syn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .all_zero_i (all_zero),
        .acc_en_o   (acc_en),
        .no_err_o   (no_err_o),
        .ready_o    (syn_ready_o)
    );

    // Map the syndromes onto the separate output buses.
    always_comb begin
        syn1_o = syn[0];
        syn2_o = syn[1];
        syn3_o = syn[2];
        syn4_o = syn[3];
    end

    assert_noerr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        no_err_o |-> ({syn1_o, syn2_o, syn3_o, syn4_o} == '0));
    assert_ready_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        syn_ready_o |-> ({syn1_o, syn2_o, syn3_o, syn4_o} != '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((no_err_o || syn_ready_o) && !start_i) |=>
            ($stable({syn1_o, syn2_o, syn3_o, syn4_o}) && $stable({no_err_o, syn_ready_o})));
endmodule

// File: tb/tb_rs_syndrome_calc.sv
module tb_rs_syndrome_calc;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] sym_i = '0;
    logic [4:0] syn1_o, syn2_o, syn3_o, syn4_o;
    logic       no_err_o, syn_ready_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] cw [31];
    logic [4:0] gen [5];

    rs_syndrome_calc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sym_i(sym_i),
        .syn1_o(syn1_o), .syn2_o(syn2_o), .syn3_o(syn3_o), .syn4_o(syn4_o),
        .no_err_o(no_err_o), .syn_ready_o(syn_ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] xt(input logic [4:0] a);
        return a[4] ? ({a[3:0], 1'b0} ^ 5'b00101) : {a[3:0], 1'b0};
    endfunction

    function automatic logic [4:0] gmul(input logic [4:0] a, input logic [4:0] b);
        logic [4:0] acc = '0;
        logic [4:0] t = a;
        for (int i = 0; i < 5; i++) begin
            if (b[i]) acc ^= t;
            t = xt(t);
        end
        return acc;
    endfunction

    function automatic logic [4:0] apow(input int e);
        logic [4:0] r = 5'd1;
        for (int i = 0; i < e % 31; i++) r = xt(r);
        return r;
    endfunction

    function automatic logic [4:0] ref_syn(input int j);
        logic [4:0] s = '0;
        for (int i = 0; i < 31; i++) s ^= gmul(cw[i], apow(j * (30 - i)));
        return s;
    endfunction

    // Generator with roots alpha^1..alpha^4, stored by degree.
    task automatic build_gen();
        logic [4:0] nx [5];
        for (int i = 0; i < 5; i++) gen[i] = '0;
        gen[0] = 5'd1;
        for (int k = 1; k <= 4; k++) begin
            for (int i = 0; i < 5; i++) nx[i] = gmul(gen[i], apow(k));
            for (int i = 1; i < 5; i++) nx[i] ^= gen[i-1];
            for (int i = 0; i < 5; i++) gen[i] = nx[i];
        end
    endtask

    // A clean codeword: a random message of degree at most 26 times the generator.
    task automatic make_clean();
        logic [4:0] m [27];
        logic [4:0] c [31];
        for (int i = 0; i < 27; i++) m[i] = 5'($urandom);
        for (int i = 0; i < 31; i++) c[i] = '0;
        for (int i = 0; i < 27; i++)
            for (int k = 0; k < 5; k++) c[i+k] ^= gmul(m[i], gen[k]);
        for (int i = 0; i < 31; i++) cw[i] = c[30 - i];
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_syn(input string req);
        chk(req, {27'd0, syn1_o}, {27'd0, ref_syn(1)});
        chk(req, {27'd0, syn2_o}, {27'd0, ref_syn(2)});
        chk(req, {27'd0, syn3_o}, {27'd0, ref_syn(3)});
        chk(req, {27'd0, syn4_o}, {27'd0, ref_syn(4)});
    endtask

    // Drive cw as one unbroken run, then check the flags and syndromes.
    task automatic run_word(input string req);
        logic exp_clean;
        exp_clean = (ref_syn(1) | ref_syn(2) | ref_syn(3) | ref_syn(4)) == '0;
        for (int i = 0; i < 31; i++) begin
            start_i = (i == 0);
            sym_i = cw[i];
            @(posedge clk); @(negedge clk);
            if (i == 0) begin
                // R2: every register holds the first symbol.
                chk("R2", {syn1_o, syn2_o, syn3_o, syn4_o}, {4{cw[0]}});
                chk("R7", {no_err_o, syn_ready_o}, 2'b00);
            end
        end
        start_i = 1'b0;
        sym_i = 5'($urandom);
        chk("R4", {no_err_o, syn_ready_o}, 2'b00);
        @(posedge clk); @(negedge clk);
        chk(exp_clean ? "R5" : "R6", {no_err_o, syn_ready_o}, exp_clean ? 2'b10 : 2'b01);
        chk_syn({"R3 ", req});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R4 watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] held;
        void'($urandom(32'd1234));
        build_gen();
        @(negedge clk); @(negedge clk);
        chk("R1 reset", {no_err_o, syn_ready_o, syn1_o, syn2_o, syn3_o, syn4_o}, '0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 idle", {no_err_o, syn_ready_o, syn1_o, syn2_o, syn3_o, syn4_o}, '0);

        // All-zero word.
        for (int i = 0; i < 31; i++) cw[i] = '0;
        run_word("zero");
        // All ones symbol pattern (31 everywhere).
        for (int i = 0; i < 31; i++) cw[i] = 5'd31;
        run_word("all31");
        // Clean codeword, then a single error at the first and the last position.
        make_clean();
        run_word("clean");
        cw[0] ^= 5'd7;
        run_word("err first");
        make_clean();
        cw[30] ^= 5'd1;
        run_word("err last");

        // R7: symbol input while idle has no effect on the outputs.
        held = {no_err_o, syn_ready_o, syn1_o, syn2_o, syn3_o, syn4_o} == '0 ? '0 : '0;
        for (int k = 0; k < 6; k++) begin
            sym_i = 5'($urandom);
            @(posedge clk); @(negedge clk);
            chk("R7 idle", {no_err_o, syn_ready_o}, 2'b01);
            chk("R7 idle syn", {27'd0, syn4_o}, {27'd0, ref_syn(4)});
        end

        // R8: abort after 12 symbols, then a clean word from the new start.
        for (int i = 0; i < 12; i++) begin
            start_i = (i == 0);
            sym_i = 5'($urandom) | 5'd1;
            @(posedge clk); @(negedge clk);
        end
        chk("R8 mid", {no_err_o, syn_ready_o}, 2'b00);
        make_clean();
        run_word("R8 restart");

        // Random words and random clean words.
        for (int n = 0; n < 30; n++) begin
            if (n % 3 == 0) make_clean();
            else for (int i = 0; i < 31; i++) cw[i] = 5'($urandom);
            run_word("random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule